// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single hardware semaphore that several requesters share. It holds a 16-bit count. A requester takes a unit by reading through a take view and gives a unit back by writing through a give view. Each take reads the count as it stood before the access and lowers it by one when it is above zero. Each give raises the count by one and never wraps past the largest value.

The take has a waiting form and a trying form. A waiting take on an empty semaphore raises `stall` in the same cycle and records the requester's ID in a waiter mask. The next give clears that mask and raises `wake` for one cycle. Woken requesters retry as new accesses, so the cell keeps no queue of pending takes.

A plain (bypass) view lets software read the count without changing it. Writes through the bypass view are dropped.

The waiter side is a three-state machine:
- `ST_CLEAR`: no requester is waiting.
- `ST_HELD`: the mask is nonzero.
- `ST_WAKE`: the one-cycle wake pulse.

Its transitions are:
- CLEAR→HELD and WAKE→HELD on a blocked take.
- HELD→WAKE on a give.
- WAKE→CLEAR when no take blocks.
- HELD→HELD while more requesters block.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the waiter mask is 0, and `wake` and `stall` are low.
- R2: A read through view 1 (take-wait) or view 2 (take-try) returns the count from before the access on `rd_data` in the same cycle. If that count is above zero, it drops by one from the next cycle.
- R3: A take-try read on a count of 0 returns 0, leaves the count at 0 and keeps `stall` low.
- R4: A take-wait read on a count of 0 raises `stall` in that cycle and leaves the count at 0. From the next cycle, bit `req_id` of `waiter_mask` is set, and bits already set stay set.
- R5: A write through view 3 (give-wait) ignores `wr_data` and raises the count by one, holding at 0xFFFF once there.
- R6: If the waiter mask is nonzero when a give is written, the next cycle shows `wake` high for exactly one cycle and `waiter_mask` at 0. A give with no waiters leaves `wake` low.
- R7: A write through view 4 (give-try) has the same effect as view 3.
- R8: A read through view 0 (bypass) returns the count and changes nothing. A write through view 0 leaves the count unchanged.
- R9: If `rd_en` and `wr_en` are high together, only the write acts. The read has no effect, and `rd_data` is 0 and `stall` is low.
- R10: View codes 5 to 7 have no effect on reads or writes, and reads through them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| view | input | 3 | Access view code |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| req_id | input | ID_W (3) | ID of the requester making the access |
| wr_data | input | CNT_W (16) | Write data, ignored by the cell |
| rd_data | output | CNT_W (16) | Read result, combinational in the access cycle |
| stall | output | 1 | Waiting take found the count empty, combinational |
| waiter_mask | output | N_REQ (8) | One bit per blocked requester |
| wake | output | 1 | One-cycle pulse releasing the waiters |

## Verification
`rd_data` and `stall` belong to the cycle of the access. The bench samples them 1 ns after driving the strobes on the falling edge, before the next rising edge.

The count, `waiter_mask` and `wake` change at the rising edge that ends the access. The bench samples them at the following falling edge and reads the count back through the bypass view. It checks `wake` again one cycle later to confirm the pulse is a single cycle.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
    typedef enum logic [2:0] {
        VW_BYPASS    = 3'd0,
        VW_TAKE_WAIT = 3'd1,
        VW_TAKE_TRY  = 3'd2,
        VW_GIVE_WAIT = 3'd3,
        VW_GIVE_TRY  = 3'd4
    } view_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_HELD  = 2'd1,
        ST_WAKE  = 2'd2
    } wait_state_e;
endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
    import sem_cell_pkg::*;
(
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [2:0] view,
    input  logic       cnt_zero,
    output logic       take_dec,
    output logic       give_inc,
    output logic       block_req,
    output logic       rd_sel
);
    logic  acc_rd;
    logic  acc_wr;
    view_e vw;

    always_comb begin
        // A write wins when both strobes are high
        acc_rd    = rd_en & ~wr_en;
        acc_wr    = wr_en;
        vw        = view_e'(view);
        take_dec  = 1'b0;
        give_inc  = 1'b0;
        block_req = 1'b0;
        rd_sel    = 1'b0;
        case (vw)
            VW_BYPASS: begin
                rd_sel = acc_rd;
            end
            VW_TAKE_WAIT: begin
                rd_sel    = acc_rd;
                take_dec  = acc_rd & ~cnt_zero;
                block_req = acc_rd & cnt_zero;
            end
            VW_TAKE_TRY: begin
                rd_sel   = acc_rd;
                take_dec = acc_rd & ~cnt_zero;
            end
            VW_GIVE_WAIT, VW_GIVE_TRY: begin
                give_inc = acc_wr;
            end
            default: begin
                rd_sel = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sem_count_reg.sv
module sem_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == CNT_MAX) |=> cnt == CNT_MAX);
    assert_take_lowers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> cnt == $past(cnt) - 1'b1);
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(cnt));
endmodule

// File: rtl/sem_waiter_fsm.sv
module sem_waiter_fsm
    import sem_cell_pkg::*;
#(
    parameter int N_REQ = 8,
    parameter int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             give,
    input  logic             block_req,
    input  logic [ID_W-1:0]  req_id,
    output logic [N_REQ-1:0] mask,
    output logic             wake
);
    wait_state_e      state_q, state_d;
    logic [N_REQ-1:0] mask_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            mask    <= '0;
        end else begin
            state_q <= state_d;
            mask    <= mask_d;
        end
    end

    always_comb begin
        state_d = state_q;
        mask_d  = mask;
        unique case (state_q)
            ST_CLEAR: begin
                if (block_req) begin
                    mask_d  = mask | (N_REQ'(1) << req_id);
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (give) begin
                    mask_d  = '0;
                    state_d = ST_WAKE;
                end else if (block_req) begin
                    mask_d = mask | (N_REQ'(1) << req_id);
                end
            end
            ST_WAKE: begin
                if (block_req) begin
                    mask_d  = mask | (N_REQ'(1) << req_id);
                    state_d = ST_HELD;
                end else begin
                    state_d = ST_CLEAR;
                end
            end
            default: begin
                state_d = ST_CLEAR;
                mask_d  = '0;
            end
        endcase
    end

    always_comb begin
        wake = (state_q == ST_WAKE);
    end

    assert_wake_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> mask == '0);
    assert_wake_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
    assert_give_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (give && mask != '0) |=> (wake && mask == '0));
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_REQ = 8,
    parameter int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       view,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  req_id,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             stall,
    output logic [N_REQ-1:0] waiter_mask,
    output logic             wake
);
    logic [CNT_W-1:0] cnt;
    logic             take_dec;
    logic             give_inc;
    logic             block_req;
    logic             rd_sel;
    logic             unused_data;

    assign unused_data = ^wr_data;

    sem_view_decode u_dec (
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .view      (view),
        .cnt_zero  (cnt == '0),
        .take_dec  (take_dec),
        .give_inc  (give_inc),
        .block_req (block_req),
        .rd_sel    (rd_sel)
    );

    sem_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (give_inc),
        .dec   (take_dec),
        .cnt   (cnt)
    );

    sem_waiter_fsm #(.N_REQ(N_REQ), .ID_W(ID_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .give      (give_inc),
        .block_req (block_req),
        .req_id    (req_id),
        .mask      (waiter_mask),
        .wake      (wake)
    );

    always_comb begin
        rd_data = rd_sel ? cnt : '0;
        stall   = block_req;
    end

    assert_stall_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (rd_data == '0 && !wr_en));
    assert_block_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> waiter_mask[$past(req_id)]);
    assert_both_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_data == '0 && !stall));
endmodule

// File: tb/test_sem_cell.sv
`timescale 1ns/1ps
module test_sem_cell;
    localparam int CNT_W = 16;
    localparam int N_REQ = 8;
    localparam int ID_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       view = '0;
    logic             rd_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [ID_W-1:0]  req_id = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic             stall;
    logic [N_REQ-1:0] waiter_mask;
    logic             wake;

    int n_chk = 0;
    int n_fail = 0;
    logic [CNT_W-1:0] got_rd;
    logic             got_stall;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    sem_cell #(.CNT_W(CNT_W), .N_REQ(N_REQ), .ID_W(ID_W)) i_sem_cell (
        .clk(clk), .rst_n(rst_n), .view(view), .rd_en(rd_en), .wr_en(wr_en),
        .req_id(req_id), .wr_data(wr_data), .rd_data(rd_data), .stall(stall),
        .waiter_mask(waiter_mask), .wake(wake)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge, capture same-cycle outputs,
    // return at the next falling edge with registered results visible.
    task automatic acc(input bit r, input bit w, input logic [2:0] v,
                       input logic [ID_W-1:0] id, input logic [CNT_W-1:0] d);
        rd_en = r; wr_en = w; view = v; req_id = id; wr_data = d;
        #1;
        got_rd = rd_data;
        got_stall = stall;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; view = 3'd0;
    endtask

    task automatic peek(input string req, input int exp);
        acc(1'b1, 1'b0, 3'd0, '0, '0);
        chk(got_rd == CNT_W'(exp), req, got_rd, exp);
    endtask

    task automatic t_reset;
        chk(waiter_mask == '0, "R1 mask", waiter_mask, 0);
        chk(!wake, "R1 wake", wake, 0);
        chk(!stall, "R1 stall", stall, 0);
        peek("R1 count", 0);
    endtask

    task automatic t_give;
        for (int i = 0; i < 3; i++) acc(1'b0, 1'b1, 3'd3, '0, 16'hBEEF);
        peek("R5 give-wait", 3);
        for (int i = 0; i < 2; i++) acc(1'b0, 1'b1, 3'd4, '0, 16'h1234);
        peek("R7 give-try", 5);
    endtask

    task automatic t_take;
        acc(1'b1, 1'b0, 3'd2, '0, '0);
        chk(got_rd == 16'd5, "R2 take-try old", got_rd, 5);
        peek("R2 after try", 4);
        acc(1'b1, 1'b0, 3'd1, '0, '0);
        chk(got_rd == 16'd4, "R2 take-wait old", got_rd, 4);
        chk(!got_stall, "R2 no stall", got_stall, 0);
        peek("R2 after wait", 3);
        for (int i = 3; i > 0; i--) begin
            acc(1'b1, 1'b0, 3'd2, '0, '0);
            chk(got_rd == CNT_W'(i), "R2 drain", got_rd, i);
        end
        acc(1'b1, 1'b0, 3'd2, '0, '0);
        chk(got_rd == '0, "R3 data", got_rd, 0);
        chk(!got_stall, "R3 stall", got_stall, 0);
        peek("R3 count", 0);
    endtask

    task automatic t_block_wake;
        acc(1'b1, 1'b0, 3'd1, 3'd2, '0);
        chk(got_stall, "R4 stall", got_stall, 1);
        chk(waiter_mask == 8'h04, "R4 mask", waiter_mask, 8'h04);
        acc(1'b1, 1'b0, 3'd1, 3'd5, '0);
        chk(got_stall, "R4 stall2", got_stall, 1);
        chk(waiter_mask == 8'h24, "R4 mask2", waiter_mask, 8'h24);
        peek("R4 count", 0);
        acc(1'b0, 1'b1, 3'd3, '0, '0);
        chk(wake, "R6 wake", wake, 1);
        chk(waiter_mask == '0, "R6 mask", waiter_mask, 0);
        @(negedge clk);
        chk(!wake, "R6 one cycle", wake, 0);
        peek("R6 count", 1);
        acc(1'b0, 1'b1, 3'd4, '0, '0);
        chk(!wake, "R6 no waiters", wake, 0);
        peek("R7 count", 2);
    endtask

    task automatic t_misc;
        acc(1'b0, 1'b1, 3'd0, '0, 16'h1234);
        peek("R8 bypass write", 2);
        acc(1'b1, 1'b1, 3'd3, '0, '0);
        chk(got_rd == '0, "R9 data", got_rd, 0);
        chk(!got_stall, "R9 stall", got_stall, 0);
        peek("R9 count", 3);
        acc(1'b1, 1'b0, 3'd6, '0, '0);
        chk(got_rd == '0, "R10 read", got_rd, 0);
        acc(1'b0, 1'b1, 3'd7, '0, 16'hFFFF);
        acc(1'b0, 1'b1, 3'd5, '0, 16'hFFFF);
        peek("R10 count", 3);
    endtask

    task automatic t_saturate;
        for (int i = 3; i < 16'hFFFF; i++) acc(1'b0, 1'b1, 3'd3, '0, '0);
        peek("R5 at max", 16'hFFFF);
        acc(1'b0, 1'b1, 3'd4, '0, '0);
        peek("R5 saturate", 16'hFFFF);
        acc(1'b1, 1'b0, 3'd2, '0, '0);
        chk(got_rd == 16'hFFFF, "R2 from max", got_rd, 16'hFFFF);
        peek("R2 below max", 16'hFFFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_give();
        t_take();
        t_block_wake();
        t_misc();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule